// File: doc/BRIEF.md
# Ping-Pong Transposing Sample Buffer

This block sits between the two passes of a row/column FFT decomposition. A frame of 128 complex samples enters in natural order, one sample per enabled clock. The block stores each frame in one half of a two-half store. While that half fills, it plays back the previous frame from the other half in stride-16 order. Each completed frame therefore leaves as eight interleaved columns of sixteen rows, ready for the second transform pass.

A single frame counter drives both ports. The write address is the counter, with the fill half selected above it. The read address is the same counter with its low three bits and high four bits exchanged, with the opposite half selected above it. At every frame boundary the halves swap roles. Fill and drain alternate indefinitely until a frame-sync pulse or a reset restarts the sequence. Playback advances only on enabled clocks, so a throttled source throttles the output at the same rate.

Top module: `tpose_pingpong_buf`

## Requirements
- R1: While reset is asserted and after its release, `out_re`, `out_im` and `out_first` are all zero until the first output sample is produced.
- R2: A cycle with `frame_sync` high stores nothing, even if `in_en` is high. It discards any partly written frame and any frame waiting to be played back. The next enabled sample is sample 0 of a new frame, and no output sample or `out_first` appears until that new frame of 128 samples is complete.
- R3: A sample is stored, and the frame position advances, only on a rising edge where `in_en` is high and `frame_sync` is low. On any other edge `out_re` and `out_im` keep their values.
- R4: After 128 samples of a frame have been stored, the next enabled edge presents the first reordered sample of that frame. Each output sample appears one clock after the enabled edge that reads it.
- R5: Output position p of a frame (p = 0..127) carries the stored sample with index (p mod 8)·16 + floor(p/8). The order is 0, 16, …, 112, 1, 17, …, 127.
- R6: Frames may arrive back to back without limit. The frame played back during any frame is the frame completed just before it, and writing the new frame never disturbs it.
- R7: `out_first` is high for exactly one clock, together with output position 0 of each played-back frame. It is low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Asynchronous reset, active high |
| frame_sync | input | 1 | Restart pulse: clears the frame position and the playback state |
| in_en | input | 1 | Sample enable; also advances playback |
| in_re | input | DW | Input sample, real part, two's complement |
| in_im | input | DW | Input sample, imaginary part, two's complement |
| out_re | output | DW | Reordered sample, real part |
| out_im | output | DW | Reordered sample, imaginary part |
| out_first | output | 1 | Marks output position 0 of each frame |

## Verification
The bench targets the frame boundary first. A design that swaps halves one cycle early or late replays a sample from the half being written, or raises `out_first` on the wrong sample. Throttled input with irregular enable gaps exposes a design whose playback runs free of the enable, which would show as drifting or repeated data. A restart pulse lands mid-playback and on a cycle with the enable high. A design that keeps the stale frame, or stores the restart-cycle sample, emits early output or shifts every later sample by one index. Random sample values across many frames catch a swapped field order in the read address, which would show up as a stride of 8 instead of 16.

// File: rtl/tpb_pkg.sv
package tpb_pkg;
   // Storage organisation of the two frame halves
   typedef enum logic [0:0] {
      TPB_MEM_UNIFIED = 1'b0,   // one array, half chosen by top address bit
      TPB_MEM_SPLIT   = 1'b1    // two arrays, one per half
   } tpb_mem_e;
endpackage

// File: rtl/tpb_addr_seq.sv
module tpb_addr_seq #(
   parameter int GRP_LOG = 3,
   parameter int ROW_LOG = 4,
   localparam int FL = GRP_LOG + ROW_LOG
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          sync_i,
   input  logic          en_i,
   output logic          we_o,
   output logic [FL:0]   waddr_o,
   output logic          re_o,
   output logic [FL:0]   raddr_o,
   output logic          first_o
);
   localparam logic [FL-1:0] LAST = '1;

   logic [FL-1:0] pos;
   logic          fill_half;
   logic          primed;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         pos       <= '0;
         fill_half <= 1'b0;
         primed    <= 1'b0;
      end else if (sync_i) begin
         pos       <= '0;
         fill_half <= 1'b0;
         primed    <= 1'b0;
      end else if (en_i) begin
         pos <= pos + 1'b1;
         if (pos == LAST) begin
            fill_half <= ~fill_half;
            primed    <= 1'b1;
         end
      end
   end

   always_comb begin
      we_o    = en_i & ~sync_i;
      re_o    = we_o & primed;
      waddr_o = {fill_half, pos};
      // exchange the two fields: stride of 2**ROW_LOG through the frame
      raddr_o = {~fill_half, pos[GRP_LOG-1:0], pos[FL-1:GRP_LOG]};
      first_o = re_o && (pos == '0);
   end

   // R2: restart returns the position to zero and drops playback
   a_r2_sync_clears: assert property (@(posedge clk) disable iff (rst)
      sync_i |=> (pos == '0) && !primed);

   // R3: no enable, no movement
   a_r3_hold_pos: assert property (@(posedge clk) disable iff (rst)
      (!en_i && !sync_i) |=> $stable(pos) && $stable(fill_half));

   // R6: the halves swap after the last position of a frame
   a_r6_half_swap: assert property (@(posedge clk) disable iff (rst)
      (en_i && !sync_i && pos == LAST) |=> (fill_half != $past(fill_half)) && primed);
endmodule

// File: rtl/tpb_store.sv
module tpb_store #(
   parameter int                 WW        = 20,
   parameter int                 AW        = 8,
   parameter tpb_pkg::tpb_mem_e  MEM_STYLE = tpb_pkg::TPB_MEM_SPLIT,
   localparam int                DEPTH     = 1 << AW,
   localparam int                HALF      = DEPTH / 2
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          we_i,
   input  logic [AW-1:0] waddr_i,
   input  logic [WW-1:0] wdata_i,
   input  logic          re_i,
   input  logic [AW-1:0] raddr_i,
   output logic [WW-1:0] rdata_o
);
   logic [WW-1:0] rd_word;

   generate
      if (MEM_STYLE == tpb_pkg::TPB_MEM_UNIFIED) begin : g_unified
         logic [WW-1:0] mem [DEPTH];
         always_ff @(posedge clk) begin
            if (we_i) mem[waddr_i] <= wdata_i;
         end
         assign rd_word = mem[raddr_i];
      end else begin : g_split
         logic [WW-1:0] half_rd [2];
         for (genvar h = 0; h < 2; h++) begin : g_half
            logic [WW-1:0] mem [HALF];
            always_ff @(posedge clk) begin
               if (we_i && (waddr_i[AW-1] == 1'(h)))
                  mem[waddr_i[AW-2:0]] <= wdata_i;
            end
            assign half_rd[h] = mem[raddr_i[AW-2:0]];
         end
         assign rd_word = half_rd[raddr_i[AW-1]];
      end
   endgenerate

   always_ff @(posedge clk or posedge rst) begin
      if (rst)       rdata_o <= '0;
      else if (re_i) rdata_o <= rd_word;
   end

   // R6: the half being read is never the half being written
   a_r6_halves_apart: assert property (@(posedge clk) disable iff (rst)
      (we_i && re_i) |-> (waddr_i[AW-1] != raddr_i[AW-1]));

   // R3: the output word moves only on a read
   a_r3_rdata_hold: assert property (@(posedge clk) disable iff (rst)
      !re_i |=> $stable(rdata_o));
endmodule

// File: rtl/tpose_pingpong_buf.sv
module tpose_pingpong_buf #(
   parameter int                 DW        = 10,
   parameter int                 GRP_LOG   = 3,
   parameter int                 ROW_LOG   = 4,
   parameter tpb_pkg::tpb_mem_e  MEM_STYLE = tpb_pkg::TPB_MEM_SPLIT
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          frame_sync,
   input  logic          in_en,
   input  logic [DW-1:0] in_re,
   input  logic [DW-1:0] in_im,
   output logic [DW-1:0] out_re,
   output logic [DW-1:0] out_im,
   output logic          out_first
);
   localparam int FL = GRP_LOG + ROW_LOG;
   localparam int AW = FL + 1;
   localparam int WW = 2 * DW;

   generate
      if (DW < 2 || DW > 32) begin : g_bad_dw
         $error("tpose_pingpong_buf: DW must lie in 2..32");
      end
      if (GRP_LOG < 1 || ROW_LOG < 1 || FL > 12) begin : g_bad_shape
         $error("tpose_pingpong_buf: field widths out of range");
      end
   endgenerate

   logic          we, re, first;
   logic [AW-1:0] waddr, raddr;
   logic [WW-1:0] rdata;

   tpb_addr_seq #(.GRP_LOG(GRP_LOG), .ROW_LOG(ROW_LOG)) u_seq (
      .clk     (clk),
      .rst     (rst),
      .sync_i  (frame_sync),
      .en_i    (in_en),
      .we_o    (we),
      .waddr_o (waddr),
      .re_o    (re),
      .raddr_o (raddr),
      .first_o (first)
   );

   tpb_store #(.WW(WW), .AW(AW), .MEM_STYLE(MEM_STYLE)) u_store (
      .clk     (clk),
      .rst     (rst),
      .we_i    (we),
      .waddr_i (waddr),
      .wdata_i ({in_re, in_im}),
      .re_i    (re),
      .raddr_i (raddr),
      .rdata_o (rdata)
   );

   always_ff @(posedge clk or posedge rst) begin
      if (rst) out_first <= 1'b0;
      else     out_first <= first;
   end

   assign out_re = rdata[WW-1:DW];
   assign out_im = rdata[DW-1:0];

   // R7: the frame marker never lasts two clocks
   a_r7_first_single: assert property (@(posedge clk) disable iff (rst)
      out_first |=> !out_first);

   // R2: a restart cycle yields neither a marker nor new data
   a_r2_sync_quiet: assert property (@(posedge clk) disable iff (rst)
      frame_sync |=> !out_first && $stable(out_re) && $stable(out_im));

   // R3: without enable the output sample holds
   a_r3_out_hold: assert property (@(posedge clk) disable iff (rst)
      !in_en |=> $stable(out_re) && $stable(out_im) && !out_first);
endmodule

// File: tb/tb_tpose_pingpong_buf.sv
module tb_tpose_pingpong_buf;
   localparam int DW = 10;
   localparam int N  = 128;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic frame_sync = 1'b0;
   logic in_en = 1'b0;
   logic [DW-1:0] in_re = '0, in_im = '0;
   logic [DW-1:0] out_re, out_im;
   logic out_first;

   always #2.5 clk = ~clk;

   tpose_pingpong_buf #(.DW(DW)) dut (
      .clk(clk), .rst(rst), .frame_sync(frame_sync), .in_en(in_en),
      .in_re(in_re), .in_im(in_im),
      .out_re(out_re), .out_im(out_im), .out_first(out_first)
   );

   int vecs = 0, miss = 0;
   bit done = 1'b0;
   string tag = "R1";

   // reference state: incoming frame, last complete frame, expectations
   int cur_re[N], cur_im[N], prv_re[N], prv_im[N];
   int wpos = 0;
   bit have = 1'b0;
   int exp_re = 0, exp_im = 0;
   bit exp_first = 1'b0, exp_valid = 1'b0;

   task automatic check_out();
      vecs++;
      if (out_first !== exp_first) begin
         miss++;
         $display("FAIL %s R4/R7 out_first actual=%0b expected=%0b pos=%0d", tag, out_first, exp_first, wpos);
      end
      if (exp_valid) begin
         vecs++;
         if (out_re !== exp_re[DW-1:0] || out_im !== exp_im[DW-1:0]) begin
            miss++;
            $display("FAIL %s R5 data actual=%h/%h expected=%h/%h", tag, out_re, out_im,
                     exp_re[DW-1:0], exp_im[DW-1:0]);
         end
      end
   endtask

   task automatic cyc(input bit st, input bit e);
      logic [DW-1:0] r, i;
      int idx;
      r = DW'($urandom);
      i = DW'($urandom);
      frame_sync = st; in_en = e; in_re = r; in_im = i;
      @(posedge clk); #1;
      exp_first = 1'b0;
      if (st) begin
         wpos = 0;
         have = 1'b0;
      end else if (e) begin
         if (have) begin
            idx = (wpos % 8) * 16 + wpos / 8;
            exp_re = prv_re[idx];
            exp_im = prv_im[idx];
            exp_first = (wpos == 0);
            exp_valid = 1'b1;
         end
         cur_re[wpos] = int'(r);
         cur_im[wpos] = int'(i);
         wpos++;
         if (wpos == N) begin
            for (int k = 0; k < N; k++) begin
               prv_re[k] = cur_re[k];
               prv_im[k] = cur_im[k];
            end
            have = 1'b1;
            wpos = 0;
         end
      end
      check_out();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         miss++;
         $display("FAIL watchdog expired in phase %s", tag);
         $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      repeat (3) @(posedge clk);
      #1;
      vecs++;
      if (out_re !== '0 || out_im !== '0 || out_first !== 1'b0) begin
         miss++;
         $display("FAIL R1 during reset actual=%h/%h/%b expected=0/0/0", out_re, out_im, out_first);
      end
      rst = 1'b0;
      @(posedge clk); #1;
      vecs++;
      if (out_re !== '0 || out_im !== '0 || out_first !== 1'b0) begin
         miss++;
         $display("FAIL R1 after reset actual=%h/%h/%b expected=0/0/0", out_re, out_im, out_first);
      end

      // R1 continued: first frame fills with no output
      tag = "R1";
      for (int k = 0; k < N; k++) cyc(1'b0, 1'b1);

      // R6: back-to-back frames, enable always high
      tag = "R6";
      for (int k = 0; k < 3 * N; k++) cyc(1'b0, 1'b1);

      // R3: alternating enable, then irregular gaps
      tag = "R3";
      for (int k = 0; k < 2 * N; k++) begin
         cyc(1'b0, 1'b1);
         cyc(1'b0, 1'b0);
      end
      for (int k = 0; k < 3 * N; k++) cyc(1'b0, ($urandom % 3) != 0);

      // R2: restart in mid-frame with enable high, then refill
      tag = "R2";
      for (int k = 0; k < 50; k++) cyc(1'b0, 1'b1);
      cyc(1'b1, 1'b1);
      for (int k = 0; k < N + 20; k++) cyc(1'b0, 1'b1);
      // R2: restart right at a frame boundary, repeated restarts
      while (wpos != 0) cyc(1'b0, 1'b1);
      cyc(1'b1, 1'b0);
      cyc(1'b1, 1'b1);
      for (int k = 0; k < 2 * N; k++) cyc(1'b0, ($urandom % 4) != 0);

      // R4/R5: several more clean frames
      tag = "R5";
      for (int k = 0; k < 2 * N + 5; k++) cyc(1'b0, 1'b1);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
      $finish;
   end
endmodule